// File: doc/BRIEF.md
# Tiled View Address Translator

This block converts a pixel position inside a two-dimensional tiled container into a 32-bit address in tiled space. Each request carries a pixel format, a three-bit view code that selects one of eight rotated or mirrored views, and the X and Y coordinates of the pixel. The returned address has the view code and the format code in its top five bits, and a scaled linear index in the bits below them.

The translation runs in four steps. The first step checks that both coordinates lie inside the usable range for the format. The second step mirrors X, Y or both by XOR with the axis mask. The third step builds a linear index, and may exchange the roles of the axes while doing so. The fourth step shifts the index left by the number of bits the format does not use. Each request also returns a line stride: the address distance between two neighbouring lines in the chosen view.

The block has two register stages and a valid/ready handshake on both sides. It accepts one request per cycle, and a stalled consumer back-pressures the producer without losing data. A coordinate that is out of range produces address zero and raises a flag.

Top module: `tiled_addr_xlate`

## Requirements
- R1: Address bits [28:27] carry the format code. 0 is 8-bit, 1 is 16-bit, 2 is 32-bit and 3 is page mode.
- R2: Address bits [31:29] carry the view code unchanged. View bit 0 (address bit 29) selects X mirroring, view bit 1 (address bit 30) selects Y mirroring, and view bit 2 (address bit 31) selects the axis exchange. Codes 0 to 7 therefore give 0°, 180° mirrored, 0° mirrored, 180°, 270° mirrored, 270°, 90° and 90° mirrored.
- R3: The per-format shift pairs (X shift, Y shift) are (0,0) for 8-bit, (0,1) for 16-bit and (1,1) for 32-bit. In page mode they equal the slot width and slot height bit counts, which default to 6 and 6. The X mask is 2^(14 - X shift) - 1 and the Y mask is 2^(13 - Y shift) - 1. A coordinate above its mask sets out_bad and forces out_addr to 0. A coordinate equal to its mask is valid.
- R4: When X mirroring is selected, X is replaced by X XOR the X mask. When Y mirroring is selected, Y is replaced by Y XOR the Y mask. Both replacements happen before the index is formed.
- R5: Without the axis exchange, the index is (Y << X bit count) + X, where the X bit count is 14 - X shift.
- R6: With the axis exchange, the index is (X << Y bit count) + Y, where the Y bit count is 13 - Y shift.
- R7: The index is shifted left by X shift + Y shift and placed in address bits [26:0].
- R8: out_stride is 1 << (13 + X shift) when the axes are exchanged. Otherwise it is 1 << (14 + Y shift).
- R9: A request accepted on one rising edge appears on the output after the next rising edge. Results come out in order, and with out_ready high the block takes and returns one request per cycle.
- R10: While out_valid is high and out_ready is low, all outputs hold their values. in_ready falls only when both stages are full, and no request is lost or duplicated.
- R11: While reset is asserted and after it is released, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge when in_valid is high |
| in_fmt | input | 2 | Pixel format code |
| in_view | input | 3 | View code (mirror X, mirror Y, exchange axes) |
| in_x | input | COORD_W (16) | X coordinate in pixels |
| in_y | input | COORD_W (16) | Y coordinate in pixels |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_addr | output | ADDR_W (32) | Tiled-space address |
| out_stride | output | ADDR_W (32) | Line stride for the view |
| out_bad | output | 1 | Coordinate was out of range |

## Verification
The bench uses the default parameters: a container of 14 by 13 bits, 6-bit slot dimensions and 16-bit coordinate inputs. The inputs are therefore wide enough to present values just above every per-format mask, and every range boundary can be reached, including the narrower page-mode range of 255 by 127. With these settings the address is exactly 32 bits wide. Every view in every format can then be compared against an index built independently from the formulas. The default two-entry depth also allows a full stall with a third request waiting at the input.

// File: rtl/tva_pkg.sv
package tva_pkg;

  typedef enum logic [1:0] {
    FMT_8B   = 2'd0,
    FMT_16B  = 2'd1,
    FMT_32B  = 2'd2,
    FMT_PAGE = 2'd3
  } tva_fmt_e;

  // positions inside the 3-bit view code
  localparam int unsigned VIEW_XINV = 0;
  localparam int unsigned VIEW_YINV = 1;
  localparam int unsigned VIEW_SWAP = 2;

endpackage

// File: rtl/tva_geom.sv
// Per-format unused-bit counts along each axis.
module tva_geom #(
  parameter int unsigned CW_BITS     = 14,
  parameter int unsigned CH_BITS     = 13,
  parameter int unsigned SLOT_W_BITS = 6,
  parameter int unsigned SLOT_H_BITS = 6,
  localparam int unsigned SH_W       = $clog2(CW_BITS + CH_BITS + 1)
) (
  input  logic [1:0]      fmt,
  output logic [SH_W-1:0] xsh,
  output logic [SH_W-1:0] ysh
);
  import tva_pkg::*;

  tva_fmt_e fmt_e;

  always_comb begin
    fmt_e = tva_fmt_e'(fmt);
    unique case (fmt_e)
      FMT_8B:   begin xsh = '0;                 ysh = '0; end
      FMT_16B:  begin xsh = '0;                 ysh = SH_W'(1); end
      FMT_32B:  begin xsh = SH_W'(1);           ysh = SH_W'(1); end
      default:  begin xsh = SH_W'(SLOT_W_BITS); ysh = SH_W'(SLOT_H_BITS); end
    endcase
  end

endmodule

// File: rtl/tva_orient.sv
// Range check and XOR mirroring of the coordinates.
module tva_orient #(
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13,
  parameter int unsigned COORD_W = 16,
  localparam int unsigned SH_W   = $clog2(CW_BITS + CH_BITS + 1)
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [SH_W-1:0]    xsh,
  input  logic [SH_W-1:0]    ysh,
  input  logic               x_inv,
  input  logic               y_inv,
  output logic [CW_BITS-1:0] xo,
  output logic [CH_BITS-1:0] yo,
  output logic               bad
);

  logic [CW_BITS-1:0] xmask;
  logic [CH_BITS-1:0] ymask;
  logic               x_over;
  logic               y_over;

  always_comb begin
    xmask  = {CW_BITS{1'b1}} >> xsh;
    ymask  = {CH_BITS{1'b1}} >> ysh;
    x_over = x > COORD_W'(xmask);
    y_over = y > COORD_W'(ymask);
    bad    = x_over | y_over;
    xo     = x[CW_BITS-1:0] ^ (x_inv ? xmask : '0);
    yo     = y[CH_BITS-1:0] ^ (y_inv ? ymask : '0);
  end

endmodule

// File: rtl/tva_pack.sv
// Linear index, format scaling, field packing and stride.
module tva_pack #(
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13,
  localparam int unsigned SH_W   = $clog2(CW_BITS + CH_BITS + 1),
  localparam int unsigned IDX_W  = CW_BITS + CH_BITS,
  localparam int unsigned ADDR_W = IDX_W + 5
) (
  input  logic [CW_BITS-1:0] xo,
  input  logic [CH_BITS-1:0] yo,
  input  logic [SH_W-1:0]    xsh,
  input  logic [SH_W-1:0]    ysh,
  input  logic [2:0]         view,
  input  logic [1:0]         fmt,
  input  logic               bad,
  output logic [ADDR_W-1:0]  addr,
  output logic [ADDR_W-1:0]  stride
);
  import tva_pkg::*;

  localparam logic [SH_W-1:0] CW_L = SH_W'(CW_BITS);
  localparam logic [SH_W-1:0] CH_L = SH_W'(CH_BITS);

  logic [SH_W-1:0]  xbits;
  logic [SH_W-1:0]  ybits;
  logic [SH_W-1:0]  align;
  logic [IDX_W-1:0] idx_row;
  logic [IDX_W-1:0] idx_col;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_sc;
  logic             swap;

  always_comb begin
    swap    = view[VIEW_SWAP];
    xbits   = CW_L - xsh;
    ybits   = CH_L - ysh;
    align   = xsh + ysh;
    idx_row = (IDX_W'(yo) << xbits) + IDX_W'(xo);
    idx_col = (IDX_W'(xo) << ybits) + IDX_W'(yo);
    idx     = swap ? idx_col : idx_row;
    idx_sc  = idx << align;
    addr    = bad ? '0 : {view, fmt, idx_sc};
    stride  = swap ? (ADDR_W'(1) << (CH_L + xsh))
                   : (ADDR_W'(1) << (CW_L + ysh));
  end

endmodule

// File: rtl/tiled_addr_xlate.sv
// Two-stage tiled-view address translator with valid/ready flow control.
module tiled_addr_xlate #(
  parameter int unsigned CW_BITS     = 14,
  parameter int unsigned CH_BITS     = 13,
  parameter int unsigned SLOT_W_BITS = 6,
  parameter int unsigned SLOT_H_BITS = 6,
  parameter int unsigned COORD_W     = 16,
  localparam int unsigned SH_W       = $clog2(CW_BITS + CH_BITS + 1),
  localparam int unsigned ADDR_W     = CW_BITS + CH_BITS + 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_fmt,
  input  logic [2:0]         in_view,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [ADDR_W-1:0]  out_stride,
  output logic               out_bad
);
  import tva_pkg::*;

  typedef struct packed {
    logic [CW_BITS-1:0] xo;
    logic [CH_BITS-1:0] yo;
    logic [2:0]         view;
    logic [1:0]         fmt;
    logic               bad;
  } s1_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] stride;
    logic              bad;
  } s2_t;

  // ---------------- stage 1 combinational ----------------
  logic [SH_W-1:0] a_xsh, a_ysh;
  s1_t             s1_nxt;

  tva_geom #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
    .SLOT_W_BITS(SLOT_W_BITS), .SLOT_H_BITS(SLOT_H_BITS)
  ) u_geom_a (
    .fmt (in_fmt),
    .xsh (a_xsh),
    .ysh (a_ysh)
  );

  tva_orient #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .COORD_W(COORD_W)
  ) u_orient (
    .x     (in_x),
    .y     (in_y),
    .xsh   (a_xsh),
    .ysh   (a_ysh),
    .x_inv (in_view[VIEW_XINV]),
    .y_inv (in_view[VIEW_YINV]),
    .xo    (s1_nxt.xo),
    .yo    (s1_nxt.yo),
    .bad   (s1_nxt.bad)
  );

  assign s1_nxt.view = in_view;
  assign s1_nxt.fmt  = in_fmt;

  // ---------------- stage 2 combinational ----------------
  s1_t             s1_q;
  s2_t             s2_nxt;
  logic [SH_W-1:0] b_xsh, b_ysh;

  tva_geom #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
    .SLOT_W_BITS(SLOT_W_BITS), .SLOT_H_BITS(SLOT_H_BITS)
  ) u_geom_b (
    .fmt (s1_q.fmt),
    .xsh (b_xsh),
    .ysh (b_ysh)
  );

  tva_pack #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS)
  ) u_pack (
    .xo     (s1_q.xo),
    .yo     (s1_q.yo),
    .xsh    (b_xsh),
    .ysh    (b_ysh),
    .view   (s1_q.view),
    .fmt    (s1_q.fmt),
    .bad    (s1_q.bad),
    .addr   (s2_nxt.addr),
    .stride (s2_nxt.stride)
  );

  assign s2_nxt.bad = s1_q.bad;

  // ---------------- flow control next state ----------------
  logic s1_v_q, s2_v_q;
  logic s1_v_d, s2_v_d;
  logic adv1, adv2;
  logic s1_en, s2_en;
  s2_t  s2_q;

  always_comb begin
    adv2   = ~s2_v_q | out_ready;
    adv1   = ~s1_v_q | adv2;
    s1_v_d = adv1 ? in_valid : s1_v_q;
    s2_v_d = adv2 ? s1_v_q   : s2_v_q;
    s1_en  = adv1 & in_valid;
    s2_en  = adv2 & s1_v_q;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0;
      s2_v_q <= 1'b0;
    end else begin
      s1_v_q <= s1_v_d;
      s2_v_q <= s2_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_en) s1_q <= s1_nxt;
  end

  always_ff @(posedge clk) begin
    if (s2_en) s2_q <= s2_nxt;
  end

  // ---------------- outputs ----------------
  assign in_ready   = adv1;
  assign out_valid  = s2_v_q;
  assign out_addr   = s2_q.addr;
  assign out_stride = s2_q.stride;
  assign out_bad    = s2_q.bad;

endmodule

// File: rtl/tva_chk.sv
module tva_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [ADDR_W-1:0] out_stride,
  input logic              out_bad
);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr)
                                 && $stable(out_stride) && $stable(out_bad));

  // R10
  stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  // R3
  bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bad |-> out_addr == '0);

  // R8
  stride_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_stride) == 1);

  // R7
  align32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_bad && out_addr[ADDR_W-4 -: 2] == 2'd2 |-> out_addr[1:0] == 2'b00);

  // R7
  align16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_bad && out_addr[ADDR_W-4 -: 2] == 2'd1 |-> out_addr[0] == 1'b0);

endmodule

bind tiled_addr_xlate tva_chk #(.ADDR_W(ADDR_W)) u_tva_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_addr   (out_addr),
  .out_stride (out_stride),
  .out_bad    (out_bad)
);

// File: tb/tb_tiled_addr_xlate.sv
`timescale 1ns/1ps
module tb_tiled_addr_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_fmt;
  logic [2:0]  in_view;
  logic [15:0] in_x;
  logic [15:0] in_y;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_addr;
  logic [31:0] out_stride;
  logic        out_bad;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  always #4 clk = ~clk;

  tiled_addr_xlate dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_view(in_view), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_stride(out_stride), .out_bad(out_bad)
  );

  // ---------------- reference from the requirements ----------------
  function automatic int sx(input logic [1:0] f);
    return (f == 2'd0) ? 0 : (f == 2'd1) ? 0 : (f == 2'd2) ? 1 : 6;
  endfunction
  function automatic int sy(input logic [1:0] f);
    return (f == 2'd0) ? 0 : 6'(f == 2'd3 ? 6 : 1);
  endfunction
  function automatic int xmask(input logic [1:0] f);
    return (1 << (14 - sx(f))) - 1;
  endfunction
  function automatic int ymask(input logic [1:0] f);
    return (1 << (13 - sy(f))) - 1;
  endfunction
  function automatic logic m_bad(input logic [1:0] f, input int x, input int y);
    return (x > xmask(f)) || (y > ymask(f));
  endfunction
  function automatic logic [31:0] m_addr(input logic [1:0] f, input logic [2:0] v,
                                         input int x, input int y);
    int xx, yy;
    logic [63:0] idx;
    if (m_bad(f, x, y)) return 32'd0;
    xx = v[0] ? (x ^ xmask(f)) : x;
    yy = v[1] ? (y ^ ymask(f)) : y;
    if (v[2]) idx = (64'(xx) << (13 - sy(f))) + 64'(yy);
    else      idx = (64'(yy) << (14 - sx(f))) + 64'(xx);
    idx = idx << (sx(f) + sy(f));
    return {v, f, idx[26:0]};
  endfunction
  function automatic logic [31:0] m_stride(input logic [1:0] f, input logic [2:0] v);
    return v[2] ? (32'd1 << (13 + sx(f))) : (32'd1 << (14 + sy(f)));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] f, input logic [2:0] v, input int x, input int y);
    in_valid = 1'b1; in_fmt = f; in_view = v; in_x = 16'(x); in_y = 16'(y);
  endtask

  // one request through an empty pipeline, with latency check
  task automatic xact(input string req, input logic [1:0] f, input logic [2:0] v,
                      input int x, input int y);
    @(negedge clk);
    chk("R11 in_ready idle", 32'(in_ready), 32'd1);
    drive(f, v, x, y);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 no early result", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R9 result after two edges", 32'(out_valid), 32'd1);
    chk(req, out_addr, m_addr(f, v, x, y));
    chk({req, " bad flag"}, 32'(out_bad), 32'(m_bad(f, x, y)));
    chk("R8 stride", out_stride, m_stride(f, v));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_fmt = '0; in_view = '0; in_x = '0; in_y = '0;
    repeat (3) @(negedge clk);
    chk("R11 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R11 in_ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic t_views();
    // R2 R4 R5 R6: all eight views, 8-bit and 32-bit
    for (int v = 0; v < 8; v++) begin
      xact("R2 R4 R5 R6 view 8b", 2'd0, 3'(v), 5, 9);
      xact("R2 R4 R5 R6 view 32b", 2'd2, 3'(v), 1234, 77);
    end
    // a hand-computed point: 8-bit, view 0, (1,1) -> (1<<14)+1
    xact("R5 literal", 2'd0, 3'd0, 1, 1);
    chk("R5 literal value", out_addr, 32'h0000_4001);
  endtask

  task automatic t_formats();
    // R1 R7: each format code in the field, with scaling
    for (int f = 0; f < 4; f++) begin
      xact("R1 R7 format view0", 2'(f), 3'd0, 37, 21);
      chk("R1 format field", 32'(out_addr[28:27]), 32'(f));
      xact("R1 R7 format view6", 2'(f), 3'd6, 100, 50);
    end
    // 16-bit literal: (1,0) -> index 1 << 1 = 2
    xact("R7 literal 16b", 2'd1, 3'd0, 1, 0);
    chk("R7 literal 16b value", out_addr, 32'h0800_0002);
  endtask

  task automatic t_bounds();
    // R3: masks valid, mask+1 invalid on each axis, every format
    for (int f = 0; f < 4; f++) begin
      xact("R3 edge valid", 2'(f), 3'd7, xmask(2'(f)), ymask(2'(f)));
      chk("R3 edge not bad", 32'(out_bad), 32'd0);
      xact("R3 x over", 2'(f), 3'd5, xmask(2'(f)) + 1, 0);
      chk("R3 x over bad", 32'(out_bad), 32'd1);
      xact("R3 y over", 2'(f), 3'd1, 0, ymask(2'(f)) + 1);
      chk("R3 y over zero", out_addr, 32'd0);
    end
    xact("R3 full-range x", 2'd0, 3'd0, 16'hFFFF, 3);
    chk("R3 page mask x", 32'(xmask(2'd3)), 32'd255);
  endtask

  task automatic t_stream();
    // R9: back-to-back, one per cycle, in order
    logic [31:0] ea [6];
    for (int i = 0; i < 6; i++) ea[i] = m_addr(2'(i % 4), 3'(i), 10 + i, 20 + i);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        chk("R9 stream valid", 32'(out_valid), 32'd1);
        chk("R9 stream order", out_addr, ea[c-2]);
      end
      if (c < 6) drive(2'(c % 4), 3'(c), 10 + c, 20 + c);
      else       in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R9 stream drained", 32'(out_valid), 32'd0);
  endtask

  task automatic t_backpressure();
    // R10: fill both stages, stall a third, then drain in order
    logic [31:0] a0, a1, a2;
    a0 = m_addr(2'd0, 3'd3, 7, 8);
    a1 = m_addr(2'd2, 3'd4, 300, 400);
    a2 = m_addr(2'd3, 3'd6, 200, 100);
    @(negedge clk);
    out_ready = 1'b0;
    drive(2'd0, 3'd3, 7, 8);
    @(negedge clk);
    drive(2'd2, 3'd4, 300, 400);
    @(negedge clk);
    drive(2'd3, 3'd6, 200, 100);
    chk("R10 in_ready low when full", 32'(in_ready), 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 held addr", out_addr, a0);
      chk("R10 held valid", 32'(out_valid), 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 second after release", out_addr, a1);
    @(negedge clk);
    chk("R10 third after release", out_addr, a2);
    chk("R10 third valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    chk("R10 drained", 32'(out_valid), 32'd0);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_views();
    t_formats();
    t_bounds();
    t_stream();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule